// File: doc/BRIEF.md
# Write Enable and Block Protect Unit

This unit guards every nonvolatile write into a 512-byte serial memory and its status register. It keeps a write-enable latch that clears itself, and two retained status fields: a block-protect code that locks an upper slice of the array and a watchdog period code. A decoder beside it sends single-cycle instruction events (set latch, clear latch, start of a write sequence). A commit request carries the target (array page or status register) and, for status writes, the new field values. The unit answers with a grant in the same cycle, or refuses.

Control is a three-state machine. ST_IDLE waits for a write sequence; the transition "open" (start event while the protect pin is high) leads to ST_PEND. From ST_PEND, "abort" (protect pin low) returns to ST_IDLE, "refuse" (commit without permission) returns to ST_IDLE, and "accept" (commit granted) goes to ST_BUSY. ST_BUSY holds through the internal write until "finish" (write-complete pulse) returns to ST_IDLE. A status write takes its new fields at grant and makes them visible when the write finishes. The assembled status byte and the watchdog code are combinational outputs.

Top module: `wep_unit`

## Requirements
- R1: Synchronous reset (rst_n low) clears the latch and returns to ST_IDLE, so status bits 1 and 0 read 0. It leaves the block-protect and watchdog codes unchanged.
- R2: A cycle with factory_default high sets the block-protect code to 00 and the watchdog code to 11 (disabled), visible from the next cycle. Nothing else sets them apart from a completed status write.
- R3: Outside ST_BUSY, a set event makes status bit 1 read 1 from the next cycle and a clear event makes it read 0.
- R4: While wp_n is low, grant stays 0, and the latch reads 0 from the following cycle.
- R5: grant is 1 in the same cycle as commit_req only when the unit is in ST_PEND, wp_n is high, the latch is set and the target is not locked.
- R6: Array commits carry a page index (address bits 8:2). Block-protect code 00 locks nothing; 01 locks pages holding 0x180 to 0x1FF; 10 locks 0x100 to 0x1FF; 11 locks the whole array. A locked page is refused as a whole. Status-register commits (commit_target 1) are never locked.
- R7: wp_n going low in ST_PEND drops the pending sequence. A later commit without a new start event is refused.
- R8: From the cycle after a grant until wr_done, the status byte reads 8'hFF (write in progress), and wp_n changes do not end it. After wr_done the latch and bit 0 read 0.
- R9: A granted status write stores commit_fields (bits 3:2 watchdog code, bits 1:0 block-protect code) and shows them once wr_done arrives. Array writes leave both codes unchanged.
- R10: Outside ST_BUSY the status byte is {2'b00, watchdog[1:0], block-protect[1:0], latch, 1'b0}, and wd_code always equals the stored watchdog code.
- R11: Set, clear and start events are ignored during ST_BUSY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of volatile state |
| factory_default | input | 1 | Loads the retained codes with their factory values |
| wp_n | input | 1 | Write-protect pin, low blocks writes |
| ins_set_wel | input | 1 | Event: set the write-enable latch |
| ins_clr_wel | input | 1 | Event: clear the write-enable latch |
| ins_write_start | input | 1 | Event: a write sequence has begun |
| commit_req | input | 1 | Request to start the internal write |
| commit_target | input | 1 | 0 array page, 1 status register |
| commit_page | input | 7 | Page index of the array write |
| commit_fields | input | 4 | New {watchdog, block-protect} codes for status writes |
| wr_done | input | 1 | Internal write finished |
| grant | output | 1 | Commit accepted this cycle |
| status_byte | output | 8 | Assembled status byte |
| wd_code | output | 2 | Stored watchdog code |

## Verification
The checker watches these rules on every cycle: grant never rises with wp_n low, without a commit, or for an array page while everything is locked. The latch is clear after a low protect pin and after a finished write. The byte reads all ones after a grant. The codes hold still except on a factory load or a finished write. Only the bench scenarios can show the region boundaries for each block-protect code, the loss of a pending sequence after an abort, events ignored during a write, codes that survive reset, and the late visibility of status-write data.

// File: rtl/wep_pkg.sv
package wep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_BUSY = 2'd2
    } wep_state_t;

    localparam logic TGT_ARRAY  = 1'b0;
    localparam logic TGT_STATUS = 1'b1;

    localparam logic [1:0] BP_NONE    = 2'b00;
    localparam logic [1:0] BP_QUARTER = 2'b01;
    localparam logic [1:0] BP_HALF    = 2'b10;
    localparam logic [1:0] BP_ALL     = 2'b11;

    localparam logic [1:0] WD_OFF = 2'b11;
endpackage

// File: rtl/wep_wel_latch.sv
module wep_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wp_n,
    input  logic busy,
    input  logic set_req,
    input  logic clr_req,
    input  logic done,
    output logic wel
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (!wp_n) begin
            wel <= 1'b0;
        end else if (busy) begin
            if (done) wel <= 1'b0;
        end else if (clr_req) begin
            wel <= 1'b0;
        end else if (set_req) begin
            wel <= 1'b1;
        end
    end
endmodule

// File: rtl/wep_region.sv
module wep_region #(
    parameter int PAGE_W = 7
) (
    input  logic [1:0]        bp,
    input  logic [PAGE_W-1:0] page,
    output logic              locked
);
    import wep_pkg::*;

    localparam int NPAGES = 1 << PAGE_W;
    localparam logic [PAGE_W:0] LIM_QUARTER = (PAGE_W+1)'(NPAGES - NPAGES / 4);
    localparam logic [PAGE_W:0] LIM_HALF    = (PAGE_W+1)'(NPAGES / 2);

    logic [PAGE_W:0] limit;

    always_comb begin
        unique case (bp)
            BP_NONE:    limit = (PAGE_W+1)'(NPAGES);
            BP_QUARTER: limit = LIM_QUARTER;
            BP_HALF:    limit = LIM_HALF;
            default:    limit = '0;
        endcase
        locked = ({1'b0, page} >= limit);
    end
endmodule

// File: rtl/wep_nvbits.sv
module wep_nvbits (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       factory_default,
    input  logic       stage_en,
    input  logic [3:0] stage_fields,
    input  logic       commit_done,
    output logic [1:0] wd,
    output logic [1:0] bp
);
    import wep_pkg::*;

    logic [3:0] stage_q;
    logic       armed_q;

    always_ff @(posedge clk) begin
        if (stage_en) stage_q <= stage_fields;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           armed_q <= 1'b0;
        else if (stage_en)    armed_q <= 1'b1;
        else if (commit_done) armed_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (factory_default) begin
            wd <= WD_OFF;
            bp <= BP_NONE;
        end else if (commit_done && armed_q) begin
            wd <= stage_q[3:2];
            bp <= stage_q[1:0];
        end
    end
endmodule

// File: rtl/wep_unit.sv
module wep_unit #(
    parameter int ADDR_W  = 9,
    parameter int PAGE_LG = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      factory_default,
    input  logic                      wp_n,
    input  logic                      ins_set_wel,
    input  logic                      ins_clr_wel,
    input  logic                      ins_write_start,
    input  logic                      commit_req,
    input  logic                      commit_target,
    input  logic [ADDR_W-PAGE_LG-1:0] commit_page,
    input  logic [3:0]                commit_fields,
    input  logic                      wr_done,
    output logic                      grant,
    output logic [7:0]                status_byte,
    output logic [1:0]                wd_code
);
    import wep_pkg::*;

    localparam int PAGE_W = ADDR_W - PAGE_LG;

    wep_state_t state_q, state_d;
    logic       wel_q;
    logic [1:0] wd_q, bp_q;
    logic       page_locked;
    logic       busy;
    logic       permit;

    assign busy = (state_q == ST_BUSY);

    wep_wel_latch u_wel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wp_n    (wp_n),
        .busy    (busy),
        .set_req (ins_set_wel),
        .clr_req (ins_clr_wel),
        .done    (wr_done),
        .wel     (wel_q)
    );

    wep_region #(.PAGE_W(PAGE_W)) u_region (
        .bp     (bp_q),
        .page   (commit_page),
        .locked (page_locked)
    );

    wep_nvbits u_nv (
        .clk             (clk),
        .rst_n           (rst_n),
        .factory_default (factory_default),
        .stage_en        (grant && (commit_target == TGT_STATUS)),
        .stage_fields    (commit_fields),
        .commit_done     (busy && wr_done),
        .wd              (wd_q),
        .bp              (bp_q)
    );

    // Permission for the current commit: pin high, latch set, target open.
    assign permit = wp_n && wel_q &&
                    ((commit_target == TGT_STATUS) || !page_locked);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ins_write_start && wp_n) state_d = ST_PEND;      // open
            ST_PEND: begin
                if (!wp_n)           state_d = ST_IDLE;                   // abort
                else if (commit_req) state_d = permit ? ST_BUSY : ST_IDLE; // accept / refuse
            end
            ST_BUSY: if (wr_done) state_d = ST_IDLE;                      // finish
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        grant       = 1'b0;
        status_byte = {2'b00, wd_q, bp_q, wel_q, 1'b0};
        unique case (state_q)
            ST_IDLE: ;
            ST_PEND: grant = commit_req && permit;
            ST_BUSY: status_byte = 8'hFF;
            default: ;
        endcase
        wd_code = wd_q;
    end
endmodule

// File: rtl/wep_unit_chk.sv
module wep_unit_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                factory_default,
    input logic                wp_n,
    input logic                commit_req,
    input logic                commit_target,
    input logic                wr_done,
    input logic                grant,
    input logic [7:0]          status_byte,
    input logic [1:0]          wd_code,
    input logic                wel_q,
    input logic [1:0]          bp_q,
    input wep_pkg::wep_state_t state_q
);
    import wep_pkg::*;

    assert_grant_needs_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> wp_n);

    assert_pin_clears_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> !wel_q);

    assert_grant_needs_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> commit_req);

    assert_full_lock_refuses_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && commit_target == TGT_ARRAY) |-> (bp_q != BP_ALL));

    assert_busy_reads_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (status_byte == 8'hFF));

    assert_finish_clears_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && wr_done) |=> !wel_q);

    assert_codes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!factory_default && !(state_q == ST_BUSY && wr_done)) |=> $stable(wd_code));

    assert_factory_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        factory_default |=> (wd_code == WD_OFF && bp_q == BP_NONE));
endmodule

bind wep_unit wep_unit_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .factory_default (factory_default),
    .wp_n            (wp_n),
    .commit_req      (commit_req),
    .commit_target   (commit_target),
    .wr_done         (wr_done),
    .grant           (grant),
    .status_byte     (status_byte),
    .wd_code         (wd_code),
    .wel_q           (wel_q),
    .bp_q            (bp_q),
    .state_q         (state_q)
);

// File: tb/tb_wep_unit.sv
`timescale 1ns/1ps
module tb_wep_unit;
    localparam int MAX_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n, factory_default, wp_n;
    logic       ins_set_wel, ins_clr_wel, ins_write_start;
    logic       commit_req, commit_target;
    logic [6:0] commit_page;
    logic [3:0] commit_fields;
    logic       wr_done;
    logic       grant;
    logic [7:0] status_byte;
    logic [1:0] wd_code;

    always #2 clk = ~clk;

    wep_unit dut (
        .clk(clk), .rst_n(rst_n), .factory_default(factory_default), .wp_n(wp_n),
        .ins_set_wel(ins_set_wel), .ins_clr_wel(ins_clr_wel),
        .ins_write_start(ins_write_start), .commit_req(commit_req),
        .commit_target(commit_target), .commit_page(commit_page),
        .commit_fields(commit_fields), .wr_done(wr_done),
        .grant(grant), .status_byte(status_byte), .wd_code(wd_code)
    );

    typedef struct {
        int         sel;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   finished = 0;

    // Monitor: pops expectations and compares against the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                logic [7:0] act;
                e = q.pop_front();
                case (e.sel)
                    0:       act = status_byte;
                    1:       act = {7'd0, grant};
                    default: act = {6'd0, wd_code};
                endcase
                n_vec++;
                if (act !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", e.tag, act, e.val);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic exp_sb(input logic [7:0] v, input string tag);
        q.push_back('{0, v, tag});
    endtask

    task automatic exp_gr(input logic v, input string tag);
        q.push_back('{1, {7'd0, v}, tag});
    endtask

    task automatic exp_wd(input logic [1:0] v, input string tag);
        q.push_back('{2, {6'd0, v}, tag});
    endtask

    task automatic flush();
        -> chk_ev;
        #0.5;
    endtask

    task automatic pulse_set();
        ins_set_wel = 1'b1; tick(); ins_set_wel = 1'b0;
    endtask

    task automatic pulse_clr();
        ins_clr_wel = 1'b1; tick(); ins_clr_wel = 1'b0;
    endtask

    task automatic pulse_start();
        ins_write_start = 1'b1; tick(); ins_write_start = 1'b0;
    endtask

    task automatic commit_only(input logic tgt, input logic [6:0] pg,
                               input logic [3:0] f, input logic g, input string tag);
        commit_req = 1'b1; commit_target = tgt; commit_page = pg; commit_fields = f;
        exp_gr(g, tag);
        flush();
        tick();
        commit_req = 1'b0;
    endtask

    task automatic do_commit(input logic tgt, input logic [6:0] pg,
                             input logic [3:0] f, input logic g, input string tag);
        pulse_start();
        commit_only(tgt, pg, f, g, tag);
    endtask

    task automatic finish_write();
        wr_done = 1'b1; tick(); wr_done = 1'b0;
    endtask

    initial begin
        #(MAX_CYC * 4);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; factory_default = 1'b1; wp_n = 1'b1;
        ins_set_wel = 1'b0; ins_clr_wel = 1'b0; ins_write_start = 1'b0;
        commit_req = 1'b0; commit_target = 1'b0; commit_page = '0;
        commit_fields = '0; wr_done = 1'b0;
        #1;
        repeat (3) tick();
        rst_n = 1'b1; factory_default = 1'b0;
        tick();
        exp_sb(8'h30, "R1 R10 reset state"); exp_wd(2'b11, "R2 factory watchdog"); flush();

        // R3: set and clear of the latch
        pulse_set(); exp_sb(8'h32, "R3 set"); flush();
        pulse_clr(); exp_sb(8'h30, "R3 clear"); flush();

        // R4: pin low clears the latch
        pulse_set();
        wp_n = 1'b0; tick(); wp_n = 1'b1;
        exp_sb(8'h30, "R4 pin clears latch"); flush();

        // R5/R8/R9: status write, busy window, pin ignored while busy
        pulse_set();
        do_commit(1'b1, 7'h00, 4'b0010, 1'b1, "R5 status write granted");
        exp_sb(8'hFF, "R8 busy reads ones"); exp_wd(2'b11, "R9 codes held until done"); flush();
        tick(); tick();
        wp_n = 1'b0; tick(); wp_n = 1'b1;
        exp_sb(8'hFF, "R8 pin low keeps write busy"); flush();
        finish_write();
        exp_sb(8'h08, "R9 R8 new codes, latch cleared"); exp_wd(2'b00, "R9 watchdog stored"); flush();

        // R6: bp=10 locks upper half
        pulse_set();
        do_commit(1'b0, 7'h41, 4'h0, 1'b0, "R6 page 0x104 locked at bp=10");
        exp_sb(8'h0A, "R6 refusal keeps latch"); flush();
        do_commit(1'b0, 7'h3F, 4'h0, 1'b1, "R6 page 0x0FC open at bp=10");
        exp_sb(8'hFF, "R8 array write busy"); flush();
        pulse_set(); pulse_start();
        finish_write();
        exp_sb(8'h08, "R11 events ignored while busy"); exp_wd(2'b00, "R9 array write keeps codes"); flush();

        // R7: abort drops pending sequence
        pulse_set(); pulse_start();
        wp_n = 1'b0; tick(); wp_n = 1'b1;
        pulse_set();
        exp_sb(8'h0A, "R7 latch re-set after abort"); flush();
        commit_only(1'b0, 7'h00, 4'h0, 1'b0, "R7 commit after abort refused");
        exp_sb(8'h0A, "R7 state idle after refusal"); flush();

        // R4: commit with pin low in the same cycle
        pulse_start();
        wp_n = 1'b0;
        commit_only(1'b0, 7'h00, 4'h0, 1'b0, "R4 grant blocked by pin");
        wp_n = 1'b1;
        exp_sb(8'h08, "R4 latch cleared by pin"); flush();

        // R5: no latch, no grant
        do_commit(1'b0, 7'h00, 4'h0, 1'b0, "R5 refused without latch");

        // R1: reset keeps retained codes
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        exp_sb(8'h08, "R1 codes survive reset"); exp_wd(2'b00, "R1 watchdog survives reset"); flush();

        // bp=01: upper quarter
        pulse_set();
        do_commit(1'b1, 7'h00, 4'b0101, 1'b1, "R5 status write bp=01");
        finish_write();
        exp_sb(8'h14, "R9 wd=01 bp=01"); exp_wd(2'b01, "R10 wd_code follows field"); flush();
        pulse_set();
        do_commit(1'b0, 7'h5F, 4'h0, 1'b1, "R6 page 0x17C open at bp=01");
        finish_write();
        pulse_set();
        do_commit(1'b0, 7'h60, 4'h0, 1'b0, "R6 page 0x180 locked at bp=01");
        exp_sb(8'h16, "R6 refusal state"); flush();

        // bp=11: everything locked, status still writable
        do_commit(1'b1, 7'h00, 4'b0011, 1'b1, "R6 status write to bp=11");
        finish_write();
        exp_sb(8'h0C, "R9 bp=11 stored"); flush();
        pulse_set();
        do_commit(1'b0, 7'h00, 4'h0, 1'b0, "R6 page 0 locked at bp=11");
        do_commit(1'b1, 7'h00, 4'b1001, 1'b1, "R6 status write open at bp=11");
        finish_write();
        exp_sb(8'h24, "R10 layout wd=10 bp=01"); exp_wd(2'b10, "R10 wd_code"); flush();

        // R2: factory default
        factory_default = 1'b1; tick(); factory_default = 1'b0;
        exp_sb(8'h30, "R2 factory codes"); exp_wd(2'b11, "R2 watchdog off"); flush();

        tick();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule